// File: doc/BRIEF.md
# Low-Power Mode Sequencer

This block decides when a small processor subsystem drops into one of three low-power modes and how it comes back. Software writes a two-bit standby select into a control register and then executes a wait-for-interrupt. On that strobe the sequencer gates clocks and, for the deepest mode, removes power from the core and peripheral domains. Only the always-on group stays powered: low-speed oscillator, real-time clock, backup RAM, pin-state retention, supply monitor, bus wake logic and display driver.

An interrupt that is both pending and enabled in the wake mask brings the system back. Reset does the same. Leaving either stop mode restores power first, then the peripheral clocks, and releases the core clock last. A one-cycle ready pulse marks the end of that sequence. Wait-for-event strobes and the core's deep-sleep hint never select or start a mode. Peripheral clocks are off after reset until software enables them in a second register.

Top module: `lpm_sequencer`

States: RUN, IDLE, STOP1, STOP2, WAKE_PWR (domains powered, clocks still gated), WAKE_CLK (peripheral clocks running, core clock gated). Transitions: RUN→IDLE/STOP1/STOP2 on a wait-for-interrupt with a valid select and no enabled pending interrupt. IDLE→RUN on wake. STOP2→WAKE_PWR on wake. STOP1→WAKE_CLK on wake. WAKE_PWR→WAKE_CLK after WAKE_STEPS cycles. WAKE_CLK→RUN after WAKE_STEPS cycles. Any state→RUN on reset.

## Requirements
- R1: Register address 0 holds the select in data bits [1:0]: 00 picks IDLE, 01 picks STOP1, 10 picks STOP2. A `wfi_strobe` in RUN enters the selected mode at the next clock edge. `mode_status` then reads 01 for IDLE, 10 for STOP1 and 11 for STOP2; it reads 00 in RUN.
- R2: A `wfi_strobe` while the select is 11 leaves the block in RUN and sets `sel_err`. `sel_err` stays set until register address 0 is written, which clears it.
- R3: `wfe_strobe` never causes entry into any low-power mode.
- R4: `deep_sleep_hint` has no effect on which mode is entered, or on whether one is entered.
- R5: A `wfi_strobe` while any bit of `irq_pending & wake_mask` is set is abandoned, and the block stays in RUN.
- R6: A low-power mode is left only when some bit of `irq_pending & wake_mask` is set. Pending interrupts whose mask bit is 0 do not wake the block.
- R7: In IDLE, `core_clk_en` is 0 and `periph_clk_en` equals the peripheral clock-enable register. Both power enables stay 1.
- R8: In STOP1, all clock enables are 0 and both power enables stay 1.
- R9: In STOP2, all clock enables and both `core_pwr_en` and `periph_pwr_en` are 0. Every bit of `aon_pwr_en` is 1 in every state.
- R10: On wake from STOP2, WAKE_STEPS cycles follow with power on and all clocks gated. Then WAKE_STEPS cycles follow with the peripheral clocks on and the core clock gated. After that the block is in RUN with `core_clk_en` at 1 and `wake_ready` high for that one cycle only. Wake from STOP1 skips the first phase. During the whole sequence `mode_status` still shows the mode being left.
- R11: On wake from IDLE, the block is in RUN after one clock edge, and `wake_ready` stays 0.
- R12: Reset gives RUN, select 00, `sel_err` 0 and a peripheral clock-enable register of all zeros. Register address 1 holds the peripheral clock enables in bits [NUM_PERIPH-1:0]. In RUN, `periph_clk_en` follows that register one cycle after a write.
- R13: Asserting `rst_n` low in any low-power mode returns the outputs to their RUN values at once, without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-running sequencer clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write enable |
| cfg_addr | input | 1 | Register select: 0 standby select, 1 peripheral clock enables |
| cfg_wdata | input | DATA_W | Register write data |
| wfi_strobe | input | 1 | Wait-for-interrupt pulse from the processor |
| wfe_strobe | input | 1 | Wait-for-event pulse; ignored |
| deep_sleep_hint | input | 1 | Core deep-sleep bit; ignored |
| irq_pending | input | NUM_IRQ | Pending interrupt lines |
| wake_mask | input | NUM_IRQ | Per-line wake enable |
| core_clk_en | output | 1 | Core clock gate enable |
| periph_clk_en | output | NUM_PERIPH | Per-peripheral clock gate enables |
| core_pwr_en | output | 1 | Core power domain enable |
| periph_pwr_en | output | 1 | Peripheral power domain enable |
| aon_pwr_en | output | NUM_AON | Always-on domain enables |
| mode_status | output | 2 | Current mode: 00 run, 01 IDLE, 10 STOP1, 11 STOP2 |
| sel_err | output | 1 | Sticky invalid-select flag |
| wake_ready | output | 1 | One-cycle pulse when a stop-mode wake completes |

## Verification
A corrupted state register shows up on the enables within one cycle. The gate and power outputs are decoded straight from the state, so a wrong state gives a clock or power pattern that the mode on `mode_status` does not allow. A wrong wake counter shifts the core clock release and `wake_ready` by whole cycles, so the bench samples every cycle of each wake phase. A select or mask slip shows as a wrong mode code on the cycle after the strobe, or as a wake that comes early or never comes.

// File: rtl/lpm_pkg.sv
package lpm_pkg;

    typedef enum logic [1:0] {
        MS_RUN   = 2'b00,
        MS_IDLE  = 2'b01,
        MS_STOP1 = 2'b10,
        MS_STOP2 = 2'b11
    } mode_stat_t;

    localparam logic [1:0] SEL_IDLE  = 2'b00;
    localparam logic [1:0] SEL_STOP1 = 2'b01;
    localparam logic [1:0] SEL_STOP2 = 2'b10;
    localparam logic [1:0] SEL_BAD   = 2'b11;

    typedef enum logic [2:0] {
        ST_RUN,
        ST_IDLE,
        ST_STOP1,
        ST_STOP2,
        ST_WAKE_PWR,
        ST_WAKE_CLK
    } lp_state_t;

endpackage

// File: rtl/lpm_regs.sv
module lpm_regs #(
    parameter int DATA_W     = 8,
    parameter int NUM_PERIPH = 4,
    parameter logic [NUM_PERIPH-1:0] PCLK_RESET = '0
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cfg_we,
    input  logic                  cfg_addr,
    input  logic [DATA_W-1:0]     cfg_wdata,
    input  logic                  bad_wfi,
    output logic [1:0]            sel_q,
    output logic [NUM_PERIPH-1:0] pclk_q,
    output logic                  sel_err
);
    logic unused_wdata;
    assign unused_wdata = ^cfg_wdata;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sel_q   <= 2'b00;
            pclk_q  <= PCLK_RESET;
            sel_err <= 1'b0;
        end else begin
            if (cfg_we && !cfg_addr) begin
                sel_q <= cfg_wdata[1:0];
            end
            if (cfg_we && cfg_addr) begin
                pclk_q <= cfg_wdata[NUM_PERIPH-1:0];
            end
            if (bad_wfi) begin
                sel_err <= 1'b1;
            end else if (cfg_we && !cfg_addr) begin
                sel_err <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/lpm_fsm.sv
module lpm_fsm
    import lpm_pkg::*;
#(
    parameter int WAKE_STEPS = 3
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wfi_strobe,
    input  logic [1:0] sel,
    input  logic       wake_req,
    output lp_state_t  state,
    output mode_stat_t mode_status,
    output logic       bad_wfi,
    output logic       wake_ready
);
    localparam int CNT_W = (WAKE_STEPS > 1) ? $clog2(WAKE_STEPS) : 1;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(WAKE_STEPS - 1);

    lp_state_t        st_q, st_n;
    logic [CNT_W-1:0] cnt_q, cnt_n;
    mode_stat_t       exit_q;
    logic             ready_q, ready_n;

    // next-state process
    always_comb begin
        st_n    = st_q;
        cnt_n   = cnt_q;
        bad_wfi = 1'b0;
        ready_n = 1'b0;
        unique case (st_q)
            ST_RUN: begin
                if (wfi_strobe) begin
                    if (sel == SEL_BAD) begin
                        bad_wfi = 1'b1;
                    end else if (!wake_req) begin
                        if (sel == SEL_IDLE)       st_n = ST_IDLE;
                        else if (sel == SEL_STOP1) st_n = ST_STOP1;
                        else                       st_n = ST_STOP2;
                    end
                end
            end
            ST_IDLE: begin
                if (wake_req) st_n = ST_RUN;
            end
            ST_STOP1: begin
                if (wake_req) begin
                    st_n  = ST_WAKE_CLK;
                    cnt_n = '0;
                end
            end
            ST_STOP2: begin
                if (wake_req) begin
                    st_n  = ST_WAKE_PWR;
                    cnt_n = '0;
                end
            end
            ST_WAKE_PWR: begin
                if (cnt_q == CNT_LAST) begin
                    st_n  = ST_WAKE_CLK;
                    cnt_n = '0;
                end else begin
                    cnt_n = cnt_q + 1'b1;
                end
            end
            ST_WAKE_CLK: begin
                if (cnt_q == CNT_LAST) begin
                    st_n    = ST_RUN;
                    ready_n = 1'b1;
                end else begin
                    cnt_n = cnt_q + 1'b1;
                end
            end
            default: st_n = ST_RUN;
        endcase
    end

    // state register process
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q    <= ST_RUN;
            cnt_q   <= '0;
            exit_q  <= MS_RUN;
            ready_q <= 1'b0;
        end else begin
            st_q    <= st_n;
            cnt_q   <= cnt_n;
            ready_q <= ready_n;
            if (st_q == ST_STOP1)      exit_q <= MS_STOP1;
            else if (st_q == ST_STOP2) exit_q <= MS_STOP2;
        end
    end

    // status output process
    always_comb begin
        unique case (st_q)
            ST_RUN:   mode_status = MS_RUN;
            ST_IDLE:  mode_status = MS_IDLE;
            ST_STOP1: mode_status = MS_STOP1;
            ST_STOP2: mode_status = MS_STOP2;
            default:  mode_status = exit_q;
        endcase
    end

    assign state      = st_q;
    assign wake_ready = ready_q;
endmodule

// File: rtl/lpm_outmux.sv
module lpm_outmux
    import lpm_pkg::*;
#(
    parameter int NUM_PERIPH = 4
) (
    input  lp_state_t             state,
    input  logic [NUM_PERIPH-1:0] pclk_q,
    output logic                  core_clk_en,
    output logic [NUM_PERIPH-1:0] periph_clk_en,
    output logic                  core_pwr_en,
    output logic                  periph_pwr_en
);
    logic pclk_open;

    always_comb begin
        core_clk_en   = 1'b0;
        pclk_open     = 1'b0;
        core_pwr_en   = 1'b1;
        periph_pwr_en = 1'b1;
        unique case (state)
            ST_RUN: begin
                core_clk_en = 1'b1;
                pclk_open   = 1'b1;
            end
            ST_IDLE:     pclk_open = 1'b1;
            ST_STOP1:    ;
            ST_STOP2: begin
                core_pwr_en   = 1'b0;
                periph_pwr_en = 1'b0;
            end
            ST_WAKE_PWR: ;
            ST_WAKE_CLK: pclk_open = 1'b1;
            default: begin
                core_clk_en = 1'b1;
                pclk_open   = 1'b1;
            end
        endcase
    end

    for (genvar i = 0; i < NUM_PERIPH; i++) begin : g_pgate
        assign periph_clk_en[i] = pclk_open & pclk_q[i];
    end
endmodule

// File: rtl/lpm_sequencer.sv
module lpm_sequencer
    import lpm_pkg::*;
#(
    parameter int DATA_W     = 8,
    parameter int NUM_PERIPH = 4,
    parameter int NUM_IRQ    = 8,
    parameter int NUM_AON    = 7,
    parameter int WAKE_STEPS = 3,
    parameter logic [NUM_PERIPH-1:0] PCLK_RESET = '0
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cfg_we,
    input  logic                  cfg_addr,
    input  logic [DATA_W-1:0]     cfg_wdata,
    input  logic                  wfi_strobe,
    input  logic                  wfe_strobe,
    input  logic                  deep_sleep_hint,
    input  logic [NUM_IRQ-1:0]    irq_pending,
    input  logic [NUM_IRQ-1:0]    wake_mask,
    output logic                  core_clk_en,
    output logic [NUM_PERIPH-1:0] periph_clk_en,
    output logic                  core_pwr_en,
    output logic                  periph_pwr_en,
    output logic [NUM_AON-1:0]    aon_pwr_en,
    output logic [1:0]            mode_status,
    output logic                  sel_err,
    output logic                  wake_ready
);
    lp_state_t             state;
    mode_stat_t            mstat;
    logic [1:0]            sel_q;
    logic [NUM_PERIPH-1:0] pclk_q;
    logic                  bad_wfi;
    logic                  wake_req;

    // event strobe and deep-sleep hint are intentionally not decoded
    logic unused_hints;
    assign unused_hints = wfe_strobe ^ deep_sleep_hint;

    assign wake_req   = |(irq_pending & wake_mask);
    assign aon_pwr_en = '1;
    assign mode_status = mstat;

    lpm_regs #(
        .DATA_W     (DATA_W),
        .NUM_PERIPH (NUM_PERIPH),
        .PCLK_RESET (PCLK_RESET)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_addr  (cfg_addr),
        .cfg_wdata (cfg_wdata),
        .bad_wfi   (bad_wfi),
        .sel_q     (sel_q),
        .pclk_q    (pclk_q),
        .sel_err   (sel_err)
    );

    lpm_fsm #(
        .WAKE_STEPS (WAKE_STEPS)
    ) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .wfi_strobe  (wfi_strobe),
        .sel         (sel_q),
        .wake_req    (wake_req),
        .state       (state),
        .mode_status (mstat),
        .bad_wfi     (bad_wfi),
        .wake_ready  (wake_ready)
    );

    lpm_outmux #(
        .NUM_PERIPH (NUM_PERIPH)
    ) u_out (
        .state         (state),
        .pclk_q        (pclk_q),
        .core_clk_en   (core_clk_en),
        .periph_clk_en (periph_clk_en),
        .core_pwr_en   (core_pwr_en),
        .periph_pwr_en (periph_pwr_en)
    );
endmodule

// File: rtl/lpm_checker.sv
module lpm_checker #(
    parameter int NUM_PERIPH = 4,
    parameter int NUM_IRQ    = 8
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  wfi_strobe,
    input logic                  wfe_strobe,
    input logic [NUM_IRQ-1:0]    irq_pending,
    input logic [NUM_IRQ-1:0]    wake_mask,
    input logic                  core_clk_en,
    input logic [NUM_PERIPH-1:0] periph_clk_en,
    input logic                  core_pwr_en,
    input logic                  periph_pwr_en,
    input logic [1:0]            mode_status,
    input logic                  sel_err,
    input logic                  wake_ready,
    input logic [1:0]            sel_q,
    input logic [NUM_PERIPH-1:0] pclk_q
);
    AST_BAD_SEL_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_status == 2'b00 && wfi_strobe && sel_q == 2'b11)
        |=> (mode_status == 2'b00 && sel_err)); // R2

    AST_WFE_NO_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_status == 2'b00 && wfe_strobe && !wfi_strobe)
        |=> (mode_status == 2'b00)); // R3

    AST_ABANDON_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_status == 2'b00 && wfi_strobe && (|(irq_pending & wake_mask)))
        |=> (mode_status == 2'b00)); // R5

    AST_MASKED_NO_WAKE: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_status != 2'b00 && !core_clk_en && !periph_pwr_en
         && !(|(irq_pending & wake_mask)))
        |=> (mode_status == 2'b11)); // R6

    AST_IDLE_GATING: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_status == 2'b01)
        |-> (!core_clk_en && periph_clk_en == pclk_q && core_pwr_en && periph_pwr_en)); // R7

    AST_STOP2_POWER: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_status == 2'b11 && !periph_pwr_en)
        |-> (!core_clk_en && periph_clk_en == '0 && !core_pwr_en)); // R9

    AST_CORE_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(core_clk_en)
        |-> (core_pwr_en && periph_pwr_en && $past(periph_pwr_en))); // R10

    AST_READY_IN_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        wake_ready |-> (core_clk_en && mode_status == 2'b00)); // R10

    AST_READY_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        wake_ready |=> !wake_ready); // R10

    AST_LP_CORE_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_status != 2'b00) |-> !core_clk_en); // R1
endmodule

bind lpm_sequencer lpm_checker #(
    .NUM_PERIPH (NUM_PERIPH),
    .NUM_IRQ    (NUM_IRQ)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .wfi_strobe    (wfi_strobe),
    .wfe_strobe    (wfe_strobe),
    .irq_pending   (irq_pending),
    .wake_mask     (wake_mask),
    .core_clk_en   (core_clk_en),
    .periph_clk_en (periph_clk_en),
    .core_pwr_en   (core_pwr_en),
    .periph_pwr_en (periph_pwr_en),
    .mode_status   (mode_status),
    .sel_err       (sel_err),
    .wake_ready    (wake_ready),
    .sel_q         (sel_q),
    .pclk_q        (pclk_q)
);

// File: tb/lpm_sequencer_bench.sv
module lpm_sequencer_bench;
    localparam int DW = 8;
    localparam int NP = 4;
    localparam int NI = 8;
    localparam int NA = 7;
    localparam int WS = 3;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          cfg_we;
    logic          cfg_addr;
    logic [DW-1:0] cfg_wdata;
    logic          wfi_strobe;
    logic          wfe_strobe;
    logic          deep_sleep_hint;
    logic [NI-1:0] irq_pending;
    logic [NI-1:0] wake_mask;
    logic          core_clk_en;
    logic [NP-1:0] periph_clk_en;
    logic          core_pwr_en;
    logic          periph_pwr_en;
    logic [NA-1:0] aon_pwr_en;
    logic [1:0]    mode_status;
    logic          sel_err;
    logic          wake_ready;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    lpm_sequencer #(
        .DATA_W (DW), .NUM_PERIPH (NP), .NUM_IRQ (NI),
        .NUM_AON (NA), .WAKE_STEPS (WS)
    ) u_lpm_sequencer (
        .clk (clk), .rst_n (rst_n), .cfg_we (cfg_we), .cfg_addr (cfg_addr),
        .cfg_wdata (cfg_wdata), .wfi_strobe (wfi_strobe), .wfe_strobe (wfe_strobe),
        .deep_sleep_hint (deep_sleep_hint), .irq_pending (irq_pending),
        .wake_mask (wake_mask), .core_clk_en (core_clk_en),
        .periph_clk_en (periph_clk_en), .core_pwr_en (core_pwr_en),
        .periph_pwr_en (periph_pwr_en), .aon_pwr_en (aon_pwr_en),
        .mode_status (mode_status), .sel_err (sel_err), .wake_ready (wake_ready)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic write_reg(input logic addr, input int data);
        cfg_we    = 1'b1;
        cfg_addr  = addr;
        cfg_wdata = DW'(data);
        @(negedge clk);
        cfg_we    = 1'b0;
    endtask

    task automatic pulse_wfi(input logic hint);
        wfi_strobe      = 1'b1;
        deep_sleep_hint = hint;
        @(negedge clk);
        wfi_strobe      = 1'b0;
        deep_sleep_hint = 1'b0;
    endtask

    // expected gate pattern for status code m (0 run,1 idle,2 stop1,3 stop2)
    task automatic check_dom(input string req, input int m, input int pclk);
        chk(req, core_clk_en, (m == 0) ? 1 : 0);
        chk(req, periph_clk_en, (m <= 1) ? pclk : 0);
        chk(req, core_pwr_en, (m == 3) ? 0 : 1);
        chk(req, periph_pwr_en, (m == 3) ? 0 : 1);
        chk("R9", aon_pwr_en, (1 << NA) - 1);
    endtask

    // wake stimulus already driven; m is the mode being left
    task automatic wake_seq(input int m, input int pclk);
        if (m == 1) begin
            @(negedge clk);
            chk("R11", mode_status, 0);
            chk("R11", core_clk_en, 1);
            chk("R11", wake_ready, 0);
            return;
        end
        if (m == 3) begin
            for (int k = 0; k < WS; k++) begin
                @(negedge clk);
                chk("R10 pwr phase status", mode_status, 3);
                chk("R10 pwr phase core pwr", core_pwr_en, 1);
                chk("R10 pwr phase periph pwr", periph_pwr_en, 1);
                chk("R10 pwr phase pclk", periph_clk_en, 0);
                chk("R10 pwr phase core clk", core_clk_en, 0);
            end
        end
        for (int k = 0; k < WS; k++) begin
            @(negedge clk);
            chk("R10 clk phase status", mode_status, m);
            chk("R10 clk phase pclk", periph_clk_en, pclk);
            chk("R10 clk phase core clk", core_clk_en, 0);
            chk("R10 clk phase ready", wake_ready, 0);
        end
        @(negedge clk);
        chk("R10 run status", mode_status, 0);
        chk("R10 run core clk", core_clk_en, 1);
        chk("R10 ready high", wake_ready, 1);
        @(negedge clk);
        chk("R10 ready one cycle", wake_ready, 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int pclk;
        rst_n = 1'b0; cfg_we = 1'b0; cfg_addr = 1'b0; cfg_wdata = '0;
        wfi_strobe = 1'b0; wfe_strobe = 1'b0; deep_sleep_hint = 1'b0;
        irq_pending = '0; wake_mask = '0;
        repeat (3) @(negedge clk);
        chk("R12 reset status", mode_status, 0);
        chk("R12 reset err", sel_err, 0);
        chk("R12 reset ready", wake_ready, 0);
        check_dom("R12 reset gates", 0, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R12: peripheral clock register sweep
        for (int p = 0; p < (1 << NP); p++) begin
            write_reg(1'b1, p);
            chk("R12 pclk follow", periph_clk_en, p);
        end
        pclk = 11;
        write_reg(1'b1, pclk);

        // R1, R2, R4: every select value with and without the deep-sleep hint
        for (int s = 0; s < 4; s++) begin
            for (int h = 0; h < 2; h++) begin
                write_reg(1'b0, s);
                chk("R2 err cleared by write", sel_err, 0);
                irq_pending = '0;
                wake_mask   = '1;
                pulse_wfi(h[0]);
                chk((h == 1) ? "R4 hint ignored" : "R1 entry", mode_status,
                    (s == 3) ? 0 : s + 1);
                if (s == 3) begin
                    chk("R2 err set", sel_err, 1);
                    @(negedge clk);
                    chk("R2 stays run", mode_status, 0);
                    chk("R2 err sticky", sel_err, 1);
                end else begin
                    check_dom((s == 0) ? "R7" : (s == 1) ? "R8" : "R9", s + 1, pclk);
                    repeat (2) @(negedge clk);
                    chk("R6 no wake without irq", mode_status, s + 1);
                    irq_pending = NI'(1 << ((s * 2 + h) % NI));
                    wake_seq(s + 1, pclk);
                    irq_pending = '0;
                    chk("R6 back in run", mode_status, 0);
                end
            end
        end

        // R3: wait-for-event never enters
        write_reg(1'b0, 2);
        for (int h = 0; h < 2; h++) begin
            wfe_strobe = 1'b1;
            deep_sleep_hint = h[0];
            @(negedge clk);
            wfe_strobe = 1'b0;
            deep_sleep_hint = 1'b0;
            chk("R3 wfe ignored", mode_status, 0);
            @(negedge clk);
            chk("R3 wfe still run", mode_status, 0);
            chk("R3 core clk on", core_clk_en, 1);
        end

        // R5: enabled pending interrupt abandons entry
        wake_mask   = 8'h10;
        irq_pending = 8'h10;
        pulse_wfi(1'b0);
        chk("R5 abandoned", mode_status, 0);
        @(negedge clk);
        chk("R5 still run", mode_status, 0);
        irq_pending = '0;

        // R6: masked pending interrupts enter and do not wake
        write_reg(1'b0, 1);
        wake_mask   = 8'h0F;
        irq_pending = 8'hF0;
        pulse_wfi(1'b0);
        chk("R6 entry despite masked irq", mode_status, 2);
        for (int k = 0; k < 5; k++) begin
            @(negedge clk);
            chk("R6 masked irq no wake", mode_status, 2);
        end
        wake_mask = '1;
        wake_seq(2, pclk);
        irq_pending = '0;

        // R13: reset in STOP2
        write_reg(1'b0, 2);
        pulse_wfi(1'b0);
        chk("R13 in stop2", mode_status, 3);
        #1 rst_n = 1'b0;
        #1;
        chk("R13 reset status", mode_status, 0);
        check_dom("R13 reset gates", 0, 0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R13 run after reset", mode_status, 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule